// File: doc/BRIEF.md
# Multi-Mode Iterative Divider

This block divides a dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder on two separate output words. One shared shift-and-subtract datapath covers five operating modes: wide (32-bit dividend) unsigned, wide signed, narrow (16-bit dividend) unsigned, narrow signed, and a signed Q15 fractional mode. Every mode runs for the same number of iteration steps, so a result always arrives at a fixed distance from the start strobe.

A host places the mode, the two dividend words and the divisor on the inputs and pulses `start` while the block is idle. The cycle that accepts `start` captures the raw operands. The first iteration step then extends the dividend to 32 bits and takes operand magnitudes. Sixteen restoring steps build the quotient magnitude, and a last step restores the signs and judges overflow. Holding `step_en` low freezes all iteration state, so an interrupted operation resumes where it stopped and returns the same answer.

Top module: `divx_core`

## Requirements
- R1: `mode` selects the operation: 0 wide unsigned, 1 wide signed, 2 narrow unsigned, 3 narrow signed, 4 Q15 signed fractional. Codes 5 to 7 behave exactly like code 2. Quotient and remainder appear on separate 16-bit outputs.
- R2: In mode 0 the dividend is the unsigned value {`dvd_hi`,`dvd_lo`}, with `dvd_hi` in bits 31:16. The block returns its unsigned quotient and remainder by `divisor`.
- R3: In mode 1 the same 32-bit word is two's complement and so is `divisor`. The quotient truncates toward zero and a nonzero remainder takes the sign of the dividend.
- R4: Modes 2 and 3 divide `dvd_lo` alone, zero-extended in mode 2 and sign-extended in mode 3, by `divisor`. `dvd_hi` has no effect on the result.
- R5: In mode 4 the quotient is the signed value of `dvd_lo` times 2^15, divided by the signed `divisor` and truncated toward zero. The remainder follows the R3 rules.
- R6: With `step_en` held high, `done` is high in the 18th cycle after the cycle in which `start` was accepted, which makes 19 cycles in all. `busy` stays high from the acceptance until `done`.
- R7: Each cycle in which `step_en` is low while `busy` is high leaves the iteration state unchanged and delays `done` by one cycle, without changing the result.
- R8: `start` is ignored while `busy` is high. It neither changes the result in progress nor produces an extra `done`.
- R9: `done` lasts exactly one cycle. `quotient`, `remainder`, `div_zero` and `overflow` keep their values from then until the next accepted `start`.
- R10: A zero divisor sets `div_zero` with `done` and keeps `overflow` low. Quotient and remainder are then undefined.
- R11: With a nonzero divisor, `overflow` is set with `done` when the true quotient lies outside the 16-bit range of the mode: 0..65535 when unsigned, -32768..32767 when signed or fractional. Quotient and remainder are then undefined.
- R12: After synchronous reset, `busy`, `done`, `div_zero` and `overflow` are low, and `quotient` and `remainder` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| step_en | input | 1 | Allow one iteration step this cycle |
| mode | input | 3 | Operation select (see R1) |
| dvd_hi | input | 16 | Upper dividend word (wide modes) |
| dvd_lo | input | 16 | Lower dividend word, or the whole dividend in narrow and fractional modes |
| divisor | input | 16 | Divisor |
| quotient | output | 16 | Quotient |
| remainder | output | 16 | Remainder |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient out of range |

## Verification
The bench builds the block with its default 16-bit word, which fixes the step count at 18. At that width a plain 64-bit integer model in the bench holds every exact quotient, so operands can be chosen freely. That makes the extreme cases reachable: the most negative wide and narrow dividends divided by minus one, a fractional dividend equal to its divisor, and a zero divisor in each mode. The same width keeps the fixed latency short enough to run paused and interrupted operations next to some 150 random operands per run.

// File: rtl/divx_pkg.sv
`timescale 1ns/1ps
package divx_pkg;
    localparam int DW    = 16;
    localparam int NSTEP = DW + 2;
    localparam int CW    = $clog2(NSTEP + 1);

    typedef enum logic [2:0] {
        DM_U32  = 3'd0,
        DM_S32  = 3'd1,
        DM_U16  = 3'd2,
        DM_S16  = 3'd3,
        DM_FRAC = 3'd4
    } dmode_e;

    typedef struct packed {
        logic [2*DW-1:0] dvd_mag;
        logic [DW-1:0]   dsr_mag;
        logic            q_neg;
        logic            r_neg;
        logic            is_signed;
    } prep_t;

    typedef struct packed {
        logic [DW-1:0] part;
        logic [DW-1:0] qd;
    } iter_t;

    typedef struct packed {
        logic [DW-1:0] quo;
        logic [DW-1:0] rem;
        logic          dbz;
        logic          ovf;
    } res_t;

    function automatic logic [2*DW-1:0] abs_wide(input logic [2*DW-1:0] v, input logic sgn);
        return (sgn && v[2*DW-1]) ? (~v + 1'b1) : v;
    endfunction

    function automatic logic [DW-1:0] abs_word(input logic [DW-1:0] v, input logic sgn);
        return (sgn && v[DW-1]) ? (~v + 1'b1) : v;
    endfunction
endpackage

// File: rtl/divx_prep.sv
`timescale 1ns/1ps
module divx_prep
    import divx_pkg::*;
(
    input  logic [2:0]    mode,
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] dv,
    output prep_t         prep
);
    logic [2*DW-1:0] ext;
    logic            sgn;

    always_comb begin
        case (dmode_e'(mode))
            DM_U32: begin
                ext = {hi, lo};
                sgn = 1'b0;
            end
            DM_S32: begin
                ext = {hi, lo};
                sgn = 1'b1;
            end
            DM_S16: begin
                ext = {{DW{lo[DW-1]}}, lo};
                sgn = 1'b1;
            end
            DM_FRAC: begin
                ext = {lo[DW-1], lo, {(DW-1){1'b0}}};
                sgn = 1'b1;
            end
            default: begin
                ext = {{DW{1'b0}}, lo};
                sgn = 1'b0;
            end
        endcase
        prep.dvd_mag   = abs_wide(ext, sgn);
        prep.dsr_mag   = abs_word(dv, sgn);
        prep.q_neg     = sgn & (ext[2*DW-1] ^ dv[DW-1]);
        prep.r_neg     = sgn & ext[2*DW-1];
        prep.is_signed = sgn;
    end
endmodule

// File: rtl/divx_stage.sv
`timescale 1ns/1ps
module divx_stage
    import divx_pkg::*;
(
    input  iter_t         cur,
    input  logic [DW-1:0] dsr_mag,
    output iter_t         nxt
);
    logic [DW:0] trial;
    logic [DW:0] diff;
    logic        fits;

    always_comb begin
        trial    = {cur.part, cur.qd[DW-1]};
        diff     = trial - {1'b0, dsr_mag};
        fits     = (trial >= {1'b0, dsr_mag});
        nxt.part = fits ? diff[DW-1:0] : trial[DW-1:0];
        nxt.qd   = {cur.qd[DW-2:0], fits};
    end
endmodule

// File: rtl/divx_final.sv
`timescale 1ns/1ps
module divx_final
    import divx_pkg::*;
(
    input  iter_t it,
    input  prep_t prep,
    input  logic  pre_ovf,
    input  logic  dbz,
    output res_t  res
);
    localparam logic [DW-1:0] NEG_LIMIT = {1'b1, {(DW-1){1'b0}}};

    logic range_bad;

    always_comb begin
        if (prep.is_signed)
            range_bad = prep.q_neg ? (it.qd > NEG_LIMIT) : it.qd[DW-1];
        else
            range_bad = 1'b0;
        res.quo = prep.q_neg ? (~it.qd + 1'b1) : it.qd;
        res.rem = prep.r_neg ? (~it.part + 1'b1) : it.part;
        res.dbz = dbz;
        res.ovf = !dbz && (pre_ovf || range_bad);
    end
endmodule

// File: rtl/divx_core.sv
`timescale 1ns/1ps
module divx_core
    import divx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          step_en,
    input  logic [2:0]    mode,
    input  logic [DW-1:0] dvd_hi,
    input  logic [DW-1:0] dvd_lo,
    input  logic [DW-1:0] divisor,
    output logic [DW-1:0] quotient,
    output logic [DW-1:0] remainder,
    output logic          busy,
    output logic          done,
    output logic          div_zero,
    output logic          overflow
);
    localparam logic [CW-1:0] LAST_C = CW'(NSTEP - 1);

    logic          busy_q, done_q, pre_ovf_q, dbz_q;
    logic [CW-1:0] cnt_q;
    logic [2:0]    mode_q;
    logic [DW-1:0] hi_q, lo_q, dv_q;
    prep_t         prep_q, prep_w;
    iter_t         it_q, stage_w;
    res_t          res_q, fin_w;

    divx_prep u_prep (
        .mode (mode_q),
        .hi   (hi_q),
        .lo   (lo_q),
        .dv   (dv_q),
        .prep (prep_w)
    );

    divx_stage u_stage (
        .cur     (it_q),
        .dsr_mag (prep_q.dsr_mag),
        .nxt     (stage_w)
    );

    divx_final u_final (
        .it      (it_q),
        .prep    (prep_q),
        .pre_ovf (pre_ovf_q),
        .dbz     (dbz_q),
        .res     (fin_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            cnt_q     <= '0;
            mode_q    <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
            dv_q      <= '0;
            prep_q    <= '0;
            it_q      <= '0;
            res_q     <= '0;
            pre_ovf_q <= 1'b0;
            dbz_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    mode_q <= mode;
                    hi_q   <= dvd_hi;
                    lo_q   <= dvd_lo;
                    dv_q   <= divisor;
                    cnt_q  <= '0;
                    busy_q <= 1'b1;
                end
            end else if (step_en) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == '0) begin
                    prep_q    <= prep_w;
                    it_q      <= '{part: prep_w.dvd_mag[2*DW-1:DW], qd: prep_w.dvd_mag[DW-1:0]};
                    pre_ovf_q <= (prep_w.dvd_mag[2*DW-1:DW] >= prep_w.dsr_mag);
                    dbz_q     <= (prep_w.dsr_mag == '0);
                end else if (cnt_q == LAST_C) begin
                    res_q  <= fin_w;
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    it_q <= stage_w;
                end
            end
        end
    end

    assign quotient  = res_q.quo;
    assign remainder = res_q.rem;
    assign div_zero  = res_q.dbz;
    assign overflow  = res_q.ovf;
    assign busy      = busy_q;
    assign done      = done_q;

    // R6
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy_q));

    // R6
    busy_drops_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    pause_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !step_en) |=> (busy_q && $stable(cnt_q) && $stable(it_q) && !done_q));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start) |=> ($stable(mode_q) && $stable(dv_q) && $stable(hi_q) && $stable(lo_q)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero) && $stable(overflow)));

    // R10
    zero_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> !overflow);
endmodule

// File: tb/divx_core_test.sv
`timescale 1ns/1ps
module divx_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        step_en = 1'b1;
    logic [2:0]  mode = '0;
    logic [15:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
    logic [15:0] quotient, remainder;
    logic        busy, done, div_zero, overflow;

    int checks = 0;
    int fails  = 0;
    longint cyc = 0;

    typedef struct {
        logic [15:0] q;
        logic [15:0] r;
        bit          dbz;
        bit          ovf;
        string       tag;
    } exp_t;

    exp_t sb[$];

    divx_core uut (
        .clk(clk), .rst(rst), .start(start), .step_en(step_en), .mode(mode),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
        .quotient(quotient), .remainder(remainder), .busy(busy), .done(done),
        .div_zero(div_zero), .overflow(overflow)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [2:0] m, input logic [15:0] hi, lo, dv, input string tag);
        exp_t e;
        longint n, d, q, r;
        bit sg;
        sg = (m == 3'd1 || m == 3'd3 || m == 3'd4);
        case (m)
            3'd0: n = longint'({hi, lo});
            3'd1: n = longint'($signed({hi, lo}));
            3'd3: n = longint'($signed(lo));
            3'd4: n = longint'($signed(lo)) * 32768;
            default: n = longint'(lo);
        endcase
        d = sg ? longint'($signed(dv)) : longint'(dv);
        e.tag = tag;
        e.dbz = (d == 0);
        e.ovf = 1'b0;
        e.q = '0;
        e.r = '0;
        if (!e.dbz) begin
            q = n / d;
            r = n % d;
            e.ovf = sg ? (q > 32767 || q < -32768) : (q > 65535);
            e.q = q[15:0];
            e.r = r[15:0];
        end
        return e;
    endfunction

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(div_zero == e.dbz, {e.tag, " R10 div_zero"}, div_zero, e.dbz);
                chk(overflow == e.ovf, {e.tag, " R11 overflow"}, overflow, e.ovf);
                if (!e.dbz && !e.ovf) begin
                    chk(quotient == e.q, {e.tag, " quotient"}, quotient, e.q);
                    chk(remainder == e.r, {e.tag, " remainder"}, remainder, e.r);
                end
            end
        end
    end

    // Driver
    task automatic run_op(input logic [2:0] m, input logic [15:0] hi, lo, dv, input string tag,
                          input int pause_at = -1, input int pause_len = 0, input bit poke = 1'b0);
        int n;
        sb.push_back(model(m, hi, lo, dv, tag));
        @(negedge clk);
        mode = m; dvd_hi = hi; dvd_lo = lo; divisor = dv;
        start = 1'b1; step_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (1) begin
            step_en = (n >= pause_at && n < pause_at + pause_len) ? 1'b0 : 1'b1;
            if (poke && n == 4) begin
                start = 1'b1; mode = 3'd2; dvd_lo = 16'h0001; divisor = 16'h0001;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
            if (done || n > 200) break;
            if (!busy) begin
                chk(1'b0, "R6 busy dropped early", n, 18 + pause_len);
                break;
            end
        end
        step_en = 1'b1;
        start = 1'b0;
        if (pause_len > 0)
            chk(n == 18 + pause_len, "R7 paused latency", n, 18 + pause_len);
        else
            chk(n == 18, "R6 latency", n, 18);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!busy && !done && !div_zero && !overflow && quotient == 0 && remainder == 0,
            "R12 reset state", {quotient, remainder}, 0);

        // R2 wide unsigned
        run_op(3'd0, 16'h0001, 16'h86A0, 16'd7, "R2");
        run_op(3'd0, 16'h1234, 16'h5678, 16'hFFFF, "R2");
        // R3 wide signed, truncation toward zero
        run_op(3'd1, 16'hFFFE, 16'h7960, 16'd7, "R3");
        run_op(3'd1, 16'h0001, 16'h86A0, 16'hFFF9, "R3");
        run_op(3'd1, 16'hFFFF, 16'h8000, 16'h0001, "R3");
        // R4 narrow modes ignore dvd_hi
        run_op(3'd2, 16'hDEAD, 16'hFFFF, 16'd10, "R4");
        run_op(3'd3, 16'hBEEF, 16'hFFF9, 16'd2, "R4");
        run_op(3'd3, 16'h1234, 16'h8000, 16'h0001, "R4");
        // R5 fractional
        run_op(3'd4, 16'h0000, 16'h2000, 16'h4000, "R5");
        run_op(3'd4, 16'h0000, 16'h4000, 16'h8000, "R5");
        run_op(3'd4, 16'h0000, 16'hE000, 16'h6000, "R5");
        // R1 spare code behaves as narrow unsigned
        run_op(3'd6, 16'hFFFF, 16'd1000, 16'd33, "R1");
        run_op(3'd7, 16'h0F0F, 16'hABCD, 16'd3, "R1");
        // R11 overflow corners
        run_op(3'd1, 16'h8000, 16'h0000, 16'hFFFF, "R11");
        run_op(3'd3, 16'h0000, 16'h8000, 16'hFFFF, "R11");
        run_op(3'd0, 16'h0005, 16'h0000, 16'h0005, "R11");
        run_op(3'd4, 16'h0000, 16'h8000, 16'h8000, "R11");
        run_op(3'd4, 16'h0000, 16'h3000, 16'h3000, "R11");
        // R10 zero divisor in every mode
        for (int m = 0; m < 5; m++)
            run_op(3'(m), 16'h1111, 16'h2222, 16'h0000, "R10");
        // R7 paused operations
        run_op(3'd1, 16'hFFF0, 16'h1234, 16'h0123, "R7", 3, 5);
        run_op(3'd4, 16'h0000, 16'hC000, 16'h7FFF, "R7", 10, 2);
        // R8 start ignored while busy
        run_op(3'd0, 16'h0000, 16'hFFFF, 16'h0007, "R8", -1, 0, 1'b1);
        repeat (3) @(negedge clk);
        chk(!busy, "R8 no restart after poke", busy, 0);

        // R9 hold after done
        run_op(3'd3, 16'h0000, 16'h0064, 16'hFFFD, "R9");
        begin
            logic [15:0] hq, hr;
            hq = quotient; hr = remainder;
            for (int k = 0; k < 5; k++) begin
                mode = 3'($urandom_range(0, 4));
                dvd_hi = 16'($urandom); dvd_lo = 16'($urandom); divisor = 16'($urandom);
                @(negedge clk);
                chk(!done && quotient == hq && remainder == hr, "R9 hold", quotient, hq);
            end
        end

        // Random operands in every mode
        for (int m = 0; m < 5; m++) begin
            for (int k = 0; k < 30; k++) begin
                logic [15:0] h, l, d;
                h = 16'($urandom) >> ($urandom % 16);
                l = 16'($urandom);
                d = 16'($urandom) >> ($urandom % 12);
                if (m == 2 || m == 3) run_op(3'(m), h, l, d, "R4");
                else if (m == 0) run_op(3'(m), h, l, d, "R2");
                else if (m == 1) run_op(3'(m), h, l, d, "R3");
                else run_op(3'(m), h, l, d, "R5");
            end
        end

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule